// File: doc/BRIEF.md
# Two-wire serial EEPROM target

This block is a two-wire bus target that makes an on-chip byte store behave like a serial EEPROM. It watches the clock and data lines, which arrive already synchronized to the system clock. From them it finds start and stop conditions, shifts in 8-bit words and acknowledges them. It serves writes of one byte or of a whole page, and reads from a given address, from the current address, or as a run of consecutive bytes. The data line is open-drain: the block only ever asks for the line to be pulled low.

A write lands first in a 64-byte page buffer. The buffer is committed to the store only when a stop condition closes a write that carried at least one data byte. A cycle-count timer then models the self-timed program cycle. While that timer runs, the block refuses its own device address, so a controller can poll until the write has finished. One parameter selects a 16K-byte or a 32K-byte address space. A second parameter sets how many bytes the backing register array really holds.

Top module: `seeprom_target`

## Requirements
- R1: Each received word takes 8 SCL clocks, MSB first. When the target accepts the word, it pulls SDA low for the whole of the ninth clock. When it sends, it releases SDA during the ninth clock and reads the controller's acknowledge there. SDA is only pulled low by a change made while SCL is low.
- R2: The first word after a start is the device word. Bits 7:4 must be 1010, bits 3:1 must equal `strap[2:0]`, and bit 0 selects read (1) or write (0). If the word does not match, it gets no acknowledge, and every clock up to the next start is ignored.
- R3: A write sends two address bytes: the high byte first, then the low byte. In the high byte, the bits above the address width are ignored. With DEPTH_SEL=0 the address is 14 bits wide and bits 7:6 are ignored. With DEPTH_SEL=1 it is 15 bits wide and bit 7 is ignored.
- R4: Data bytes of a write go to consecutive addresses. Only address bits 5:0 count up, and they wrap inside the 64-byte page. A later byte sent to the same location replaces the earlier one.
- R5: The buffered bytes reach the store only when a stop follows at least one data byte. A write that carries no data, or that is cut off by a repeated start, leaves the store unchanged and starts no program cycle.
- R6: After a committing stop, the device word gets no acknowledge for WR_CYCLES system clocks. After that time it is acknowledged again, and reads return the new data.
- R7: A random read is a write of the device word and the two address bytes, then a repeated start and the device word with the read bit set. It returns the byte at the given address.
- R8: A read with no address phase starts at the internal address counter. The counter is 0 after reset. After a write, it holds one past the last written location, counting within the page.
- R9: Each byte sent advances the counter by one. After the top address (all ones in the address width), it wraps to 0.
- R10: A sequential read goes on while the controller acknowledges. After a not-acknowledge, the target leaves SDA released until the next start.
- R11: A start anywhere, even in the middle of a word, drops the transfer in progress and begins decoding a new device word.
- R12: The store holds 2^STORE_AW bytes and is cleared by reset. A location is selected by the low STORE_AW bits of the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized bus clock line |
| sda_i | input | 1 | Synchronized bus data line, as seen on the wire |
| strap | input | 3 | Hard-wired device select bits |
| sda_oe | output | 1 | When 1, pull the data line low |

## Verification
The bus events are decoded from the live line values against a one-cycle delayed copy, and the drive register follows them. So `sda_oe` settles one system clock after the SCL falling edge that calls for it. The bench holds each SCL phase for four system clocks and samples SDA two clocks into the high phase. This puts every acknowledge and data bit well after it is due and well before it may change. Store contents become visible only after the full WR_CYCLES program window. The bench therefore never reads back right after a stop. It polls with the device word until the word is acknowledged, and it checks that the first poll after a committing stop is refused.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;

    localparam logic [3:0] DEV_CODE = 4'b1010;
    localparam int         PAGE_AW  = 6;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_AHI,
        PH_ALO,
        PH_WDAT,
        PH_RDAT
    } phase_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } line_ev_t;

    function automatic int addr_bits(input int depth_sel);
        return (depth_sel != 0) ? 15 : 14;
    endfunction

    function automatic logic dev_match(input logic [7:0] w, input logic [2:0] sel);
        return (w[7:4] == DEV_CODE) && (w[3:1] == sel);
    endfunction

endpackage

// File: rtl/seeprom_linecond.sv
module seeprom_linecond
    import seeprom_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev.start = scl_q & scl_i & sda_q & ~sda_i;
        ev.stop  = scl_q & scl_i & ~sda_q & sda_i;
        ev.rise  = scl_i & ~scl_q;
        ev.fall  = ~scl_i & scl_q;
        ev.sda   = sda_i;
    end

endmodule

// File: rtl/seeprom_wtimer.sv
module seeprom_wtimer #(
    parameter int unsigned CYCLES = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic kick,
    output logic busy
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (kick) begin
            cnt <= CW'(CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign busy = (cnt != '0);

    AST_KICK_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        kick |-> !busy);  // R6

endmodule

// File: rtl/seeprom_pagebuf.sv
module seeprom_pagebuf #(
    parameter int PG_AW  = 6,
    parameter int OUT_AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic [OUT_AW-1:0] base,
    input  logic              load,
    input  logic [PG_AW-1:0]  load_idx,
    input  logic [7:0]        load_data,
    input  logic              commit,
    input  logic              busy,
    output logic              wr_en,
    output logic [OUT_AW-1:0] wr_addr,
    output logic [7:0]        wr_data
);

    localparam int PB = 1 << PG_AW;

    logic [7:0]              data_q [PB];
    logic [PB-1:0]           valid_q;
    logic [OUT_AW-PG_AW-1:0] page_q;
    logic                    walking;
    logic [PG_AW-1:0]        idx;

    always_ff @(posedge clk) begin
        if (load) begin
            data_q[load_idx] <= load_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            page_q  <= '0;
            walking <= 1'b0;
            idx     <= '0;
        end else begin
            if (clear) begin
                valid_q <= '0;
                page_q  <= base[OUT_AW-1:PG_AW];
            end
            if (load) begin
                valid_q[load_idx] <= 1'b1;
            end
            if (commit) begin
                walking <= 1'b1;
                idx     <= '0;
            end else if (walking) begin
                idx <= idx + PG_AW'(1);
                if (idx == '1) begin
                    walking <= 1'b0;
                    valid_q <= '0;
                end
            end
        end
    end

    assign wr_en   = walking & valid_q[idx];
    assign wr_addr = {page_q, idx};
    assign wr_data = data_q[idx];

    AST_WALK_INSIDE_BUSY: assert property (@(posedge clk) disable iff (rst)
        walking |-> busy);  // R6

endmodule

// File: rtl/seeprom_target.sv
module seeprom_target
    import seeprom_pkg::*;
#(
    parameter int DEPTH_SEL = 0,
    parameter int STORE_AW  = 10,
    parameter int WR_CYCLES = 500000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap,
    output logic       sda_oe
);

    localparam int AW      = addr_bits(DEPTH_SEL);
    localparam int HI_BITS = AW - 8;
    localparam int STORE_N = 1 << STORE_AW;

    line_ev_t            ev;
    logic                busy;
    phase_e              ph;
    phase_e              nxt_q;
    logic [3:0]          bitcnt;
    logic                in_ack;
    logic [7:0]          sh;
    logic [7:0]          tx;
    logic [AW-1:0]       ptr;
    logic [HI_BITS-1:0]  hi_q;
    logic                got_data;
    logic [7:0]          mem [STORE_N];
    logic [7:0]          rd_byte;
    logic [AW-1:0]       set_addr;
    logic                byte_done;
    logic                byte_ack;
    logic                pb_clear;
    logic                pb_load;
    logic                commit;
    logic                pb_we;
    logic [STORE_AW-1:0] pb_addr;
    logic [7:0]          pb_data;

    seeprom_linecond u_line (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    seeprom_wtimer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .kick (commit),
        .busy (busy)
    );

    seeprom_pagebuf #(.PG_AW(PAGE_AW), .OUT_AW(STORE_AW)) u_page (
        .clk       (clk),
        .rst       (rst),
        .clear     (pb_clear),
        .base      (set_addr[STORE_AW-1:0]),
        .load      (pb_load),
        .load_idx  (ptr[PAGE_AW-1:0]),
        .load_data (sh),
        .commit    (commit),
        .busy      (busy),
        .wr_en     (pb_we),
        .wr_addr   (pb_addr),
        .wr_data   (pb_data)
    );

    always_comb begin
        rd_byte   = mem[ptr[STORE_AW-1:0]];
        set_addr  = {hi_q, sh};
        byte_done = (ph inside {PH_DEV, PH_AHI, PH_ALO, PH_WDAT}) && !in_ack
                    && ev.fall && (bitcnt == 4'd8);
        byte_ack  = (ph == PH_DEV) ? (dev_match(sh, strap) && !busy) : 1'b1;
        pb_clear  = byte_done && (ph == PH_ALO);
        pb_load   = byte_done && (ph == PH_WDAT);
        commit    = ev.stop && (ph == PH_WDAT) && got_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STORE_N; i++) begin
                mem[i] <= '0;
            end
        end else if (pb_we) begin
            mem[pb_addr] <= pb_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            nxt_q    <= PH_IDLE;
            bitcnt   <= '0;
            in_ack   <= 1'b0;
            sh       <= '0;
            tx       <= '0;
            ptr      <= '0;
            hi_q     <= '0;
            got_data <= 1'b0;
            sda_oe   <= 1'b0;
        end else if (ev.start) begin
            ph       <= PH_DEV;
            bitcnt   <= '0;
            in_ack   <= 1'b0;
            got_data <= 1'b0;
            sda_oe   <= 1'b0;
        end else if (ev.stop) begin
            ph       <= PH_IDLE;
            bitcnt   <= '0;
            in_ack   <= 1'b0;
            got_data <= 1'b0;
            sda_oe   <= 1'b0;
        end else begin
            case (ph)
                PH_DEV, PH_AHI, PH_ALO, PH_WDAT: begin
                    if (!in_ack) begin
                        if (ev.rise && bitcnt != 4'd8) begin
                            sh     <= {sh[6:0], ev.sda};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (byte_done) begin
                            bitcnt <= '0;
                            if (!byte_ack) begin
                                ph <= PH_IDLE;
                            end else begin
                                in_ack <= 1'b1;
                                sda_oe <= 1'b1;
                                case (ph)
                                    PH_DEV:  nxt_q <= sh[0] ? PH_RDAT : PH_AHI;
                                    PH_AHI: begin
                                        hi_q  <= sh[HI_BITS-1:0];
                                        nxt_q <= PH_ALO;
                                    end
                                    PH_ALO: begin
                                        ptr   <= set_addr;
                                        nxt_q <= PH_WDAT;
                                    end
                                    default: begin
                                        ptr[PAGE_AW-1:0] <= ptr[PAGE_AW-1:0] + PAGE_AW'(1);
                                        got_data         <= 1'b1;
                                        nxt_q            <= PH_WDAT;
                                    end
                                endcase
                            end
                        end
                    end else if (ev.fall) begin
                        in_ack <= 1'b0;
                        ph     <= nxt_q;
                        if (nxt_q == PH_RDAT) begin
                            tx     <= rd_byte;
                            sda_oe <= ~rd_byte[7];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                end
                PH_RDAT: begin
                    if (!in_ack) begin
                        if (ev.rise && bitcnt != 4'd8) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (ev.fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                in_ack <= 1'b1;
                                ptr    <= ptr + AW'(1);
                            end else begin
                                sda_oe <= ~tx[3'd7 - bitcnt[2:0]];
                            end
                        end
                    end else begin
                        if (ev.rise && ev.sda) begin
                            ph     <= PH_IDLE;
                            in_ack <= 1'b0;
                        end else if (ev.fall) begin
                            in_ack <= 1'b0;
                            bitcnt <= '0;
                            tx     <= rd_byte;
                            sda_oe <= ~rd_byte[7];
                        end
                    end
                end
                default: begin
                    sda_oe <= 1'b0;
                end
            endcase
        end
    end

    AST_RELEASE_FOR_CTRL_ACK: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_RDAT && in_ack) |-> !sda_oe);  // R1

    AST_PULL_AFTER_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !$past(scl_i));  // R1

    AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_DEV && busy) |-> !sda_oe);  // R6

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_IDLE) |-> !sda_oe);  // R10

    AST_START_REDECODES: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (ph == PH_DEV && !sda_oe));  // R11

endmodule

// File: tb/tb_seeprom_target.sv
module tb_seeprom_target;

    localparam int       AW     = 14;
    localparam int       SAW    = 10;
    localparam int       WRC    = 300;
    localparam int       Q      = 4;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_line;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0]    mdl [1 << SAW];
    logic [AW-1:0] mptr;
    logic [7:0]    wbuf [80];

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    seeprom_target #(.DEPTH_SEL(0), .STORE_AW(SAW), .WR_CYCLES(WRC)) dut (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl),
        .sda_i  (sda_line),
        .strap  (STRAP),
        .sda_oe (sda_oe)
    );

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hold(Q);
        scl = 1'b1;   hold(Q);
        sda_m = 1'b0; hold(Q);
        scl = 1'b0;   hold(Q);
    endtask

    task automatic bus_stop();
        scl = 1'b0;   sda_m = 1'b0; hold(Q);
        scl = 1'b1;   hold(Q);
        sda_m = 1'b1; hold(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hold(Q);
            scl = 1'b1;   hold(Q);
            scl = 1'b0;
        end
        sda_m = 1'b1; hold(Q);
        scl = 1'b1;   hold(2);
        ack = ~sda_line;
        hold(2);
        scl = 1'b0;   hold(1);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hold(Q);
            scl = 1'b1; hold(2);
            b[i] = sda_line;
            hold(2);
            scl = 1'b0;
        end
        sda_m = nack; hold(Q);
        scl = 1'b1;   hold(Q);
        scl = 1'b0;   hold(1);
        sda_m = 1'b1;
    endtask

    function automatic logic [AW-1:0] in_page(input logic [AW-1:0] a, input int k);
        logic [5:0] off;
        off = a[5:0] + 6'(k);
        return {a[AW-1:6], off};
    endfunction

    // write n bytes from wbuf; dc goes into the ignored high bits (R3)
    task automatic do_write(input logic [AW-1:0] a, input int n, input logic [1:0] dc);
        logic ack;
        logic [AW-1:0] t;
        bus_start();
        send_byte(DEV_W, ack);
        chk(ack, "R2 device word acknowledged", ack, 1);
        send_byte({dc, a[13:8]}, ack);
        chk(ack, "R3 high address acknowledged", ack, 1);
        send_byte(a[7:0], ack);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ack);
            chk(ack, "R1 data byte acknowledged", ack, 1);
        end
        bus_stop();
        for (int i = 0; i < n; i++) begin
            t = in_page(a, i);
            mdl[t[SAW-1:0]] = wbuf[i];
        end
        mptr = in_page(a, n);
    endtask

    task automatic poll_ready(input bit expect_busy);
        logic ack;
        int tries;
        tries = 0;
        ack = 1'b0;
        while (!ack && tries < 40) begin
            bus_start();
            send_byte(DEV_W, ack);
            bus_stop();
            if (tries == 0) begin
                chk(ack == !expect_busy, "R6 first poll after stop", ack, !expect_busy);
            end
            tries++;
        end
        chk(ack, "R6 acknowledge returns after program cycle", ack, 1);
    endtask

    task automatic read_bytes(input int n);
        logic [7:0] b;
        for (int i = 0; i < n; i++) begin
            recv_byte(i == n - 1, b);
            chk(b == mdl[mptr[SAW-1:0]], "R9 sequential read byte", b, mdl[mptr[SAW-1:0]]);
            mptr = mptr + AW'(1);
        end
    endtask

    task automatic rand_read(input logic [AW-1:0] a, input int n);
        logic ack;
        bus_start();
        send_byte(DEV_W, ack);
        send_byte({2'b00, a[13:8]}, ack);
        send_byte(a[7:0], ack);
        bus_start();
        send_byte(DEV_R, ack);
        chk(ack, "R7 read device word acknowledged", ack, 1);
        mptr = a;
        read_bytes(n);
        bus_stop();
    endtask

    task automatic cur_read(input int n);
        logic ack;
        bus_start();
        send_byte(DEV_R, ack);
        chk(ack, "R8 current read acknowledged", ack, 1);
        read_bytes(n);
        bus_stop();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
        finish_run();
    end

    initial begin
        logic ack;
        logic [7:0] b;
        logic [AW-1:0] a;
        int n;
        void'($urandom(32'd4242));
        for (int i = 0; i < (1 << SAW); i++) mdl[i] = 8'h00;
        mptr = '0;
        hold(5);
        rst = 1'b0;
        hold(3);
        chk(sda_oe == 1'b0, "R1 line released after reset", sda_oe, 0);

        // R8 R12: counter starts at 0, store cleared
        cur_read(2);

        // R2: wrong strap, then wrong code; following word ignored
        bus_start();
        send_byte({4'b1010, STRAP ^ 3'b001, 1'b0}, ack);
        chk(!ack, "R2 wrong strap refused", ack, 0);
        send_byte(8'h00, ack);
        chk(!ack, "R2 words after mismatch ignored", ack, 0);
        bus_stop();
        bus_start();
        send_byte({4'b1011, STRAP, 1'b1}, ack);
        chk(!ack, "R2 wrong device code refused", ack, 0);
        bus_stop();

        // R4 R6 R7: single byte write
        wbuf[0] = 8'hA5;
        do_write(14'h0010, 1, 2'b00);
        poll_ready(1'b1);
        rand_read(14'h0010, 1);

        // R4: page wrap from offset 0x3C
        for (int i = 0; i < 8; i++) wbuf[i] = 8'h30 + 8'(i);
        do_write(14'h017C, 8, 2'b00);
        poll_ready(1'b1);
        rand_read(14'h0140, 4);
        rand_read(14'h017C, 4);

        // R4: 70 bytes overwrite the first six of the page
        for (int i = 0; i < 70; i++) wbuf[i] = 8'(8'hC0 ^ i);
        do_write(14'h0200, 70, 2'b00);
        poll_ready(1'b1);
        // R8: counter one past last written within page
        cur_read(3);
        rand_read(14'h0200, 8);

        // R3: ignored high bits set
        wbuf[0] = 8'h5E;
        do_write(14'h1234, 1, 2'b11);
        poll_ready(1'b1);
        rand_read(14'h1234, 1);

        // R5: address-only write then stop; no program cycle
        bus_start();
        send_byte(DEV_W, ack);
        send_byte(8'h00, ack);
        send_byte(8'h10, ack);
        bus_stop();
        mptr = 14'h0010;
        poll_ready(1'b0);
        cur_read(1);

        // R5: data cut off by repeated start is not committed
        bus_start();
        send_byte(DEV_W, ack);
        send_byte(8'h00, ack);
        send_byte(8'h10, ack);
        send_byte(8'h99, ack);
        mptr = 14'h0011;
        bus_start();
        send_byte(DEV_R, ack);
        read_bytes(1);
        bus_stop();
        poll_ready(1'b0);
        rand_read(14'h0010, 1);
        chk(mdl[10'h010] == 8'hA5, "R5 model keeps old byte", mdl[10'h010], 8'hA5);

        // R9 R12: wrap from top address to 0, aliased store
        rand_read(14'h3FFE, 4);

        // R10: after not-acknowledge the line stays released
        rand_read(14'h0010, 1);
        bus_start();
        send_byte(DEV_R, ack);
        recv_byte(1'b1, b);
        chk(b == mdl[mptr[SAW-1:0]], "R10 byte before nack", b, mdl[mptr[SAW-1:0]]);
        mptr = mptr + AW'(1);
        recv_byte(1'b1, b);
        chk(b == 8'hFF, "R10 released after nack", b, 8'hFF);
        bus_stop();

        // R11: start in mid-word restarts decoding
        bus_start();
        for (int i = 0; i < 4; i++) begin
            sda_m = 1'b1; hold(Q);
            scl = 1'b1;   hold(Q);
            scl = 1'b0;
        end
        bus_start();
        send_byte(DEV_R, ack);
        chk(ack, "R11 device word after mid-word start", ack, 1);
        read_bytes(1);
        bus_stop();

        // random writes and reads
        for (int it = 0; it < 20; it++) begin
            a = AW'($urandom);
            n = 1 + int'($urandom % 8);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            do_write(a, n, 2'($urandom));
            poll_ready(1'b1);
            rand_read(a, n);
        end

        finish_run();
    end

endmodule